// File: doc/BRIEF.md
# MFM Floppy Read-Data Separator

This block turns the clockless read-data line of a floppy drive into a stream of raw MFM bit cells. The line rests high, and every flux transition arrives as a short low pulse. The block brings the line into the system clock domain and samples it at a fixed rate of several samples per bit cell. It finds each falling edge, then places that edge in the nearest legal bit-cell slot. The cell timing restarts at every edge, so slow drift in motor speed does not build up over time.

Each recovered cell comes out as a one-clock strobe with a data bit. A cell that holds a transition gives a 1. Each cell that passes with no transition gives a 0. A long quiet gap, such as the space between sectors, makes the block go idle. While idle it sends nothing, so the gap does not fill the stream with zeros. MFM decoding, the search for the sync word and the host transfer belong to logic further downstream. Two parameters set the nominal rate: the number of system clocks per sample, and the number of samples per cell.

Top module: `mfm_data_separator`

## Requirements
- R1: After a synchronous reset, raw_valid and raw_bit are both 0, and the block is idle.
- R2: While idle, the first falling edge of rd_n seen at a sample gives one strobe with raw_bit = 1. Strobes come only in the clock that follows a sample tick, through a two-flop synchronizer and a one-sample edge detector.
- R3: Transitions spaced exactly 2, 3 or 4 cells apart give a 1, then 1, 2 or 3 zeros, then a 1.
- R4: With C samples per cell and H = C/2, an edge is counted against the last cell centre. An edge that arrives before C+H samples, or exactly at C+H, closes the next cell with a 1. Each C+H, C+H+C, ... point that passes with no edge first emits a 0. For example, with C = 8, spacings of 14, 19 and 20 samples give 1,0,1, and a spacing of 21 samples gives 1,0,0,1.
- R5: Cell timing restarts at every accepted edge. Spacings that are each late by H-1 samples therefore never add up into an extra cell.
- R6: A falling edge that arrives fewer than H samples after an emitted transition gives no bit. Later timing is measured from that edge.
- R7: After 3 zeros in a row, if the next C+H point passes with no edge, the block emits nothing more and goes idle. The next edge then gives a 1 with no zeros before it.
- R8: raw_valid is high for at most one clock at a time.
- R9: The line is read once per sample. A low pulse one sample long is still seen as a transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_n | input | 1 | Asynchronous read-data line; rests high, low pulse per flux transition |
| raw_valid | output | 1 | One-clock strobe, one per recovered bit cell |
| raw_bit | output | 1 | Cell value when raw_valid is high: 1 means a transition, 0 means an empty cell |

## Verification
Some rules are checked on every cycle by assertions. A strobe is never two clocks long. A strobe always follows a sample tick. A zero comes out only while the block is locked. Every entry into the locked state starts with a 1. The phase counter stays below the timeout point. Other behaviour can only be shown by the bench's scenarios, which compare against a reference model cycle by cycle and check whole bit sequences. That covers how edge spacing maps to cell counts, including the exact tie at the timeout point. It also covers the restart of timing that stops late edges from adding up, the absorbing of too-early edges, going idle after a long gap, and the detection of one-sample pulses.

// File: rtl/mfm_sep_pkg.sv
// Shared types for the MFM read-data separator.
package mfm_sep_pkg;
    // Tracker state: waiting for a first edge, or following cell timing.
    typedef enum logic {
        SEP_IDLE = 1'b0,
        SEP_LOCK = 1'b1
    } sep_state_t;
endpackage

// File: rtl/mfm_tick_gen.sv
// Sample-rate tick generator.
// Makes a tick that is high for one clock in every DIV clocks.
// Assumes DIV >= 2, so ticks never fall on two clocks in a row.
module mfm_tick_gen #(
    parameter int DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_cnt;

    // Count clocks modulo DIV.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_cnt <= '0;
        else if (div_cnt == LAST)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + 1'b1;
    end

    assign tick = (div_cnt == LAST);
endmodule

// File: rtl/mfm_edge_front.sv
// Input front end: two-flop synchronizer and sampled falling-edge detector.
// On each tick the synchronized level is read once. That one value is compared
// with the stored level and also becomes the new stored level.
// Assumes the line rests high.
module mfm_edge_front (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_n,
    input  logic tick,
    output logic fall
);
    logic sync_a, sync_b, last_lvl;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
        end else begin
            sync_a <= rd_n;
            sync_b <= sync_a;
        end
    end

    // Keep the level seen at the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_lvl <= 1'b1;
        else if (tick)
            last_lvl <= sync_b;
    end

    // A high-to-low change between two samples is a transition.
    assign fall = tick & last_lvl & ~sync_b;
endmodule

// File: rtl/mfm_cell_tracker.sv
// Bit-cell tracker.
// Counts samples from the last cell centre. An edge at or after half a cell
// closes the next cell with a 1, and the count restarts at that edge. Each
// cell-and-a-half point with no edge emits a 0 and moves the reference on by
// one cell. After MAX_EMPTY zeros, the next timeout sends the tracker idle.
// Assumes tick is never high on two clocks in a row.
module mfm_cell_tracker
    import mfm_sep_pkg::*;
#(
    parameter int CELL      = 8,
    parameter int MAX_EMPTY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fall,
    output logic raw_valid,
    output logic raw_bit
);
    localparam int HALF = CELL / 2;
    localparam int TMO  = CELL + HALF;
    localparam int PW   = $clog2(TMO + 1);
    localparam int EW   = $clog2(MAX_EMPTY + 1);
    localparam logic [PW-1:0] HALF_V = PW'(HALF);
    localparam logic [PW-1:0] TMO_V  = PW'(TMO);
    localparam logic [EW-1:0] MAXE_V = EW'(MAX_EMPTY);

    sep_state_t    state;
    logic [PW-1:0] phase;
    logic [PW-1:0] phase_nx;
    logic [EW-1:0] empty;

    // Sample count as it will be at this tick.
    always_comb phase_nx = phase + 1'b1;

    // Place edges into cells, time out empty cells, drop to idle on long gaps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEP_IDLE;
            phase     <= '0;
            empty     <= '0;
            raw_valid <= 1'b0;
            raw_bit   <= 1'b0;
        end else begin
            raw_valid <= 1'b0;
            if (tick) begin
                if (state == SEP_IDLE) begin
                    if (fall) begin
                        raw_valid <= 1'b1;
                        raw_bit   <= 1'b1;
                        phase     <= '0;
                        empty     <= '0;
                        state     <= SEP_LOCK;
                    end
                end else if (fall) begin
                    if (phase_nx >= HALF_V) begin
                        raw_valid <= 1'b1;
                        raw_bit   <= 1'b1;
                    end
                    phase <= '0;
                    empty <= '0;
                end else if (phase_nx == TMO_V) begin
                    if (empty == MAXE_V) begin
                        state <= SEP_IDLE;
                        phase <= '0;
                    end else begin
                        raw_valid <= 1'b1;
                        raw_bit   <= 1'b0;
                        phase     <= HALF_V;
                        empty     <= empty + 1'b1;
                    end
                end else begin
                    phase <= phase_nx;
                end
            end
        end
    end

    logic locked;
    assign locked = (state == SEP_LOCK);

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid |=> !raw_valid);

    assert_strobe_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid |-> $past(tick));

    assert_zero_only_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_valid && !raw_bit) |-> locked);

    assert_lock_opens_with_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (raw_valid && raw_bit));

    assert_phase_below_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phase < TMO_V);
endmodule

// File: rtl/mfm_data_separator.sv
// MFM read-data separator top level.
// Gets raw MFM bit cells back from a clockless read-data line that rests high.
// TICK_DIV system clocks make one sample, and CELL_SAMPLES samples make one bit cell.
// Assumes TICK_DIV >= 2 and CELL_SAMPLES >= 4.
module mfm_data_separator #(
    parameter int TICK_DIV     = 25,
    parameter int CELL_SAMPLES = 8,
    parameter int MAX_EMPTY    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_n,
    output logic raw_valid,
    output logic raw_bit
);
    logic tick;
    logic fall;

    mfm_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    mfm_edge_front u_front (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_n  (rd_n),
        .tick  (tick),
        .fall  (fall)
    );

    mfm_cell_tracker #(.CELL(CELL_SAMPLES), .MAX_EMPTY(MAX_EMPTY)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .fall      (fall),
        .raw_valid (raw_valid),
        .raw_bit   (raw_bit)
    );
endmodule

// File: tb/sim_mfm_data_separator.sv
// Bench for the MFM read-data separator.
// A behavioural model runs every clock and is compared with the outputs.
// Whole scenarios are also checked as bit sequences built from the edge spacings.
module sim_mfm_data_separator;
    localparam int DIV  = 4;
    localparam int CELL = 8;
    localparam int HALF = CELL / 2;
    localparam int TMO  = CELL + HALF;
    localparam int MAXE = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_n = 1'b1;
    logic raw_valid, raw_bit;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mfm_data_separator #(.TICK_DIV(DIV), .CELL_SAMPLES(CELL), .MAX_EMPTY(MAXE)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_n      (rd_n),
        .raw_valid (raw_valid),
        .raw_bit   (raw_bit)
    );

    // Reference model: sample timing and cell rules, stepped once per clock.
    int mdiv, mph, mempty;
    bit m1, m2, mprev, mlock, ev, eb;
    always @(posedge clk) begin
        bit smp, fe;
        if (!rst_n) begin
            mdiv = 0; m1 = 1; m2 = 1; mprev = 1; mlock = 0;
            mph = 0; mempty = 0; ev = 0; eb = 0;
        end else begin
            ev = 0;
            if (mdiv == DIV - 1) begin
                mdiv = 0;
                smp = m2;
                fe = mprev && !smp;
                mprev = smp;
                if (!mlock) begin
                    if (fe) begin ev = 1; eb = 1; mlock = 1; mph = 0; mempty = 0; end
                end else if (fe) begin
                    if (mph + 1 >= HALF) begin ev = 1; eb = 1; end
                    mph = 0; mempty = 0;
                end else if (mph + 1 == TMO) begin
                    if (mempty == MAXE) begin mlock = 0; mph = 0; end
                    else begin ev = 1; eb = 0; mph = HALF; mempty++; end
                end else begin
                    mph++;
                end
            end else begin
                mdiv++;
            end
            m2 = m1;
            m1 = rd_n;
        end
    end

    // Cycle compare, strobe width check and capture of the emitted bits.
    bit got[$];
    bit last_valid = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (raw_valid !== ev || (ev && raw_bit !== eb)) begin
                bad++;
                $display("FAIL R2/R4 cycle model: valid=%0b bit=%0b expected valid=%0b bit=%0b",
                         raw_valid, raw_bit, ev, eb);
            end
            if (raw_valid) begin
                total++;
                if (last_valid) begin
                    bad++;
                    $display("FAIL R8 strobe width: valid high 2 clocks, expected 1");
                end
                got.push_back(raw_bit);
            end
            last_valid = raw_valid;
        end
    end

    int sp[$];
    bit expq[$];

    task automatic samples(input int n);
        repeat (n * DIV) @(negedge clk);
    endtask

    // Build the expected bits from the spacing rules of R3, R4, R6 and R7.
    task automatic build_expect();
        expq.delete();
        expq.push_back(1'b1);
        foreach (sp[i]) begin
            if (sp[i] >= HALF) begin
                for (int k = 0; k < MAXE; k++)
                    if (TMO + k * CELL < sp[i]) expq.push_back(1'b0);
                expq.push_back(1'b1);
            end
        end
        for (int k = 0; k < MAXE; k++) expq.push_back(1'b0);
    endtask

    // Drive the edges with the given spacings, then a long quiet gap, and compare.
    task automatic run_seq(input string tag, input int pw);
        build_expect();
        got.delete();
        foreach (sp[i]) begin
            rd_n = 1'b0; samples(pw);
            rd_n = 1'b1; samples(sp[i] - pw);
        end
        rd_n = 1'b0; samples(pw);
        rd_n = 1'b1; samples(60);
        total++;
        if (got.size() != expq.size()) begin
            bad++;
            $display("FAIL %s: got %0d bits, expected %0d", tag, got.size(), expq.size());
        end else begin
            foreach (expq[i]) begin
                if (got[i] !== expq[i]) begin
                    bad++;
                    $display("FAIL %s: bit %0d is %0b, expected %0b", tag, i, got[i], expq[i]);
                    break;
                end
            end
        end
        sp.delete();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs right after reset.
        total++;
        if (raw_valid !== 1'b0 || raw_bit !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: valid=%0b bit=%0b expected 0 0", raw_valid, raw_bit);
        end
        samples(50);
        // R1: a quiet line emits nothing while idle.
        total++;
        if (got.size() != 0) begin
            bad++;
            $display("FAIL R1 idle: got %0d bits, expected 0", got.size());
        end

        // R2 R3: legal spacings of 2, 3 and 4 cells.
        sp.push_back(16); sp.push_back(24); sp.push_back(32); sp.push_back(16);
        run_seq("R3 legal spacings", 3);

        // R4: early, late and tied edges snap to the nearest cell.
        sp.push_back(14); sp.push_back(19); sp.push_back(20); sp.push_back(21);
        sp.push_back(13); sp.push_back(27);
        run_seq("R4 snapping", 3);

        // R5: steady late edges do not add up.
        for (int i = 0; i < 6; i++) sp.push_back(19);
        run_seq("R5 restart", 3);

        // R6: an edge too soon after a transition is absorbed.
        sp.push_back(16); sp.push_back(3); sp.push_back(16); sp.push_back(2); sp.push_back(24);
        run_seq("R6 absorb", 1);

        // R7: a gap past the last timeout goes idle, then restarts with a 1.
        sp.push_back(40); sp.push_back(16); sp.push_back(70);
        run_seq("R7 idle gap", 3);

        // R9: one-sample pulses are still seen.
        sp.push_back(16); sp.push_back(24); sp.push_back(16);
        run_seq("R9 short pulse", 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R7 watchdog: run did not end, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule